// File: doc/BRIEF.md
# Locking Packet Timestamp Capture Slots

This block keeps hardware timestamps for packets in flight on a network port, with one capture slot for the transmit direction and one for the receive direction. Both slots watch the same free-running 64-bit time input. When the packet path asserts a slot's capture request, the slot copies the current time and marks itself valid. From that point the slot is locked. Later requests are refused, so the stored value always belongs to exactly one packet.

Software reads the captured time through a small register port. It reads the low word first and the high word second. Reading the high word returns the upper half and unlocks the slot in the same step. Each slot has a control word that holds a software-written enable bit, the read-only valid bit, and a sticky flag that records a request refused while the slot was locked. Reading the control word clears that flag. The packet-buffer side and the time counter are outside this block.

Top module: `tsc_capture_pair`

## Requirements
- R1: After reset, every control word reads zero (enable, valid and missed all clear) and both stamp words of both slots read zero.
- R2: A capture request to a slot that is enabled and not valid stores `time_i` as it is on that cycle. From the next cycle the slot is valid, with bits [31:0] readable at register select 1 and bits [63:32] at register select 2.
- R3: While a slot is valid, its stored stamp does not change, whatever requests arrive.
- R4: A read of the high word (select 2) clears the slot's valid bit on the next cycle. A read of the low word (select 1) leaves it set.
- R5: While the enable bit (control bit 0) is clear, capture requests are ignored: the valid bit stays clear and the missed flag is not set.
- R6: When a high-word read and an enabled capture request reach the same slot in the same cycle, the read wins. The slot ends up not valid, the stamp is unchanged, and the request counts as dropped.
- R7: The missed flag (control bit 2) is set by a dropped request (enabled, and the slot either valid or being released in that cycle). A control-word read clears it, unless another drop happens in the same cycle, in which case the flag stays set.
- R8: Slot 0 (transmit) takes `cap_req_i[0]` and slot 1 (receive) takes `cap_req_i[1]`. Address bits [2] select the slot and bits [1:0] select the register. Activity on one slot never changes the other.
- R9: A write to the control word sets the enable bit from `reg_wbit_i` and nothing else. Writes to the stamp words have no effect. Register select 3 reads zero.
- R10: Read data is combinational. It shows the register state from before the clock edge at which the read takes effect, so a high-word read returns the stamp that it releases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_i | input | 64 | Current time value to be captured |
| cap_req_i | input | 2 | Per-slot capture request (bit 0 transmit, bit 1 receive) |
| reg_rd_i | input | 1 | Register read strobe, side effects at the clock edge |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | {slot, register select} |
| reg_wbit_i | input | 1 | Enable value written to a control word |
| reg_rdata_o | output | 32 | Read data for the addressed register |

## Verification
For each slot, the bench sweeps all sixteen combinations of enable, already-locked, simultaneous high-word read and capture request. It then reads back both control words and both stamp words. These combinations separate a real capture from refusal because of the lock, from refusal because of the gate, and from a release that wins over a request, and each outcome leaves its own control bits and stamp. Separate sequences cover a control read that coincides with a new drop, low-word reads that must not release, and writes to stamp addresses. A reserved-select read is also tried. Throughout, the other slot's control word is read back to show that the two slots stay independent.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_RSV  = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_VALID_BIT = 1;
    localparam int CTRL_MISS_BIT  = 2;
endpackage

// File: rtl/tsc_slot.sv
module tsc_slot #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_i,
    input  logic              req_i,
    input  logic              ctrl_wr_i,
    input  logic              en_wdata_i,
    input  logic              ctrl_rd_i,
    input  logic              hi_rd_i,
    output logic              en_o,
    output logic              valid_o,
    output logic              missed_o,
    output logic [TIME_W-1:0] stamp_o
);
    typedef struct packed {
        logic              en;
        logic              valid;
        logic              missed;
        logic [TIME_W-1:0] stamp;
    } slot_t;

    slot_t st_d, st_q;
    logic  take, drop;

    always_comb begin
        st_d = st_q;
        take = req_i && st_q.en && !st_q.valid && !hi_rd_i;
        drop = req_i && st_q.en && (st_q.valid || hi_rd_i);
        if (ctrl_wr_i) st_d.en = en_wdata_i;
        if (hi_rd_i)   st_d.valid = 1'b0;
        if (take) begin
            st_d.valid = 1'b1;
            st_d.stamp = time_i;
        end
        if (ctrl_rd_i) st_d.missed = 1'b0;
        if (drop)      st_d.missed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o     = st_q.en;
    assign valid_o  = st_q.valid;
    assign missed_o = st_q.missed;
    assign stamp_o  = st_q.stamp;
endmodule

// File: rtl/tsc_regmux.sv
module tsc_regmux
    import tsc_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32,
    parameter int CH_W   = 1,
    localparam int ADDR_W = CH_W + 2,
    localparam int TIME_W = 2 * DATA_W
) (
    input  logic                          rd_i,
    input  logic                          wr_i,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic [NUM_CH-1:0]             en_i,
    input  logic [NUM_CH-1:0]             valid_i,
    input  logic [NUM_CH-1:0]             missed_i,
    input  logic [NUM_CH-1:0][TIME_W-1:0] stamp_i,
    output logic [NUM_CH-1:0]             ctrl_rd_o,
    output logic [NUM_CH-1:0]             hi_rd_o,
    output logic [NUM_CH-1:0]             ctrl_wr_o,
    output logic [DATA_W-1:0]             rdata_o
);
    reg_sel_e          sel;
    logic [CH_W-1:0]   ch_field;
    logic [NUM_CH-1:0] hit;

    assign sel      = reg_sel_e'(addr_i[1:0]);
    assign ch_field = addr_i[ADDR_W-1:2];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
        assign hit[c]       = (ch_field == CH_W'(c));
        assign ctrl_rd_o[c] = rd_i && hit[c] && (sel == SEL_CTRL);
        assign hi_rd_o[c]   = rd_i && hit[c] && (sel == SEL_HI);
        assign ctrl_wr_o[c] = wr_i && hit[c] && (sel == SEL_CTRL);
    end

    always_comb begin
        rdata_o = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (hit[c]) begin
                case (sel)
                    SEL_CTRL: begin
                        rdata_o[CTRL_EN_BIT]    = en_i[c];
                        rdata_o[CTRL_VALID_BIT] = valid_i[c];
                        rdata_o[CTRL_MISS_BIT]  = missed_i[c];
                    end
                    SEL_LO:  rdata_o = stamp_i[c][DATA_W-1:0];
                    SEL_HI:  rdata_o = stamp_i[c][TIME_W-1:DATA_W];
                    default: rdata_o = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tsc_capture_pair.sv
module tsc_capture_pair #(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32,
    localparam int TIME_W = 2 * DATA_W,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_i,
    input  logic [NUM_CH-1:0] cap_req_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wbit_i,
    output logic [DATA_W-1:0] reg_rdata_o
);
    logic [NUM_CH-1:0]             en_w, valid_w, missed_w;
    logic [NUM_CH-1:0]             ctrl_rd_w, hi_rd_w, ctrl_wr_w;
    logic [NUM_CH-1:0][TIME_W-1:0] stamp_w;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        tsc_slot #(.TIME_W(TIME_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .time_i     (time_i),
            .req_i      (cap_req_i[c]),
            .ctrl_wr_i  (ctrl_wr_w[c]),
            .en_wdata_i (reg_wbit_i),
            .ctrl_rd_i  (ctrl_rd_w[c]),
            .hi_rd_i    (hi_rd_w[c]),
            .en_o       (en_w[c]),
            .valid_o    (valid_w[c]),
            .missed_o   (missed_w[c]),
            .stamp_o    (stamp_w[c])
        );
    end

    tsc_regmux #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_mux (
        .rd_i      (reg_rd_i),
        .wr_i      (reg_wr_i),
        .addr_i    (reg_addr_i),
        .en_i      (en_w),
        .valid_i   (valid_w),
        .missed_i  (missed_w),
        .stamp_i   (stamp_w),
        .ctrl_rd_o (ctrl_rd_w),
        .hi_rd_o   (hi_rd_w),
        .ctrl_wr_o (ctrl_wr_w),
        .rdata_o   (reg_rdata_o)
    );
endmodule

// File: rtl/tsc_capture_chk.sv
module tsc_capture_chk #(
    parameter int NUM_CH = 2,
    parameter int TIME_W = 64
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [TIME_W-1:0]             time_i,
    input logic [NUM_CH-1:0]             req,
    input logic [NUM_CH-1:0]             en,
    input logic [NUM_CH-1:0]             valid,
    input logic [NUM_CH-1:0]             missed,
    input logic [NUM_CH-1:0]             ctrl_rd,
    input logic [NUM_CH-1:0]             hi_rd,
    input logic [NUM_CH-1:0][TIME_W-1:0] stamp
);
    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_rd, hi_rd}));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
            en[c] && !valid[c] && req[c] && !hi_rd[c]
            |=> valid[c] && (stamp[c] == $past(time_i)));

        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            valid[c] && !hi_rd[c] |=> valid[c] && $stable(stamp[c]));

        p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
            hi_rd[c] |=> !valid[c]);

        p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !en[c] && !valid[c] |=> !valid[c]);

        p_read_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            hi_rd[c] && req[c] && en[c] |=> missed[c] && !valid[c] && $stable(stamp[c]));

        p_miss_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ctrl_rd[c] && !(req[c] && en[c]) |=> !missed[c]);
    end
endmodule

bind tsc_capture_pair tsc_capture_chk #(.NUM_CH(NUM_CH), .TIME_W(TIME_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .time_i  (time_i),
    .req     (cap_req_i),
    .en      (en_w),
    .valid   (valid_w),
    .missed  (missed_w),
    .ctrl_rd (ctrl_rd_w),
    .hi_rd   (hi_rd_w),
    .stamp   (stamp_w)
);

// File: tb/tsc_capture_pair_tb.sv
`timescale 1ns/1ps
module tsc_capture_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_i = '0;
    logic [1:0]  cap_req = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wbit = 1'b0;
    logic [31:0] reg_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model of the requirements
    logic        m_en  [2];
    logic        m_val [2];
    logic        m_mis [2];
    logic [63:0] m_st  [2];

    always #10 clk = ~clk;

    tsc_capture_pair u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .time_i      (time_i),
        .cap_req_i   (cap_req),
        .reg_rd_i    (reg_rd),
        .reg_wr_i    (reg_wr),
        .reg_addr_i  (reg_addr),
        .reg_wbit_i  (reg_wbit),
        .reg_rdata_o (reg_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, check read data (R10), apply model at posedge
    task automatic cyc(input logic [1:0] req, input logic rd, input logic wr,
                       input logic [2:0] addr, input logic wb,
                       input logic [63:0] tm, input string tag);
        logic [31:0] exp;
        int ch;
        @(negedge clk);
        cap_req = req; reg_rd = rd; reg_wr = wr; reg_addr = addr;
        reg_wbit = wb; time_i = tm;
        #1;
        ch = int'(addr[2]);
        if (rd) begin
            case (addr[1:0])
                2'd0: exp = {29'd0, m_mis[ch], m_val[ch], m_en[ch]};
                2'd1: exp = m_st[ch][31:0];
                2'd2: exp = m_st[ch][63:32];
                default: exp = 32'd0;
            endcase
            check(tag, reg_rdata, exp);
        end
        @(posedge clk);
        for (int c = 0; c < 2; c++) begin
            logic sel_c, crd, hrd, cwr, take, drop;
            sel_c = (int'(addr[2]) == c);
            crd = rd && sel_c && addr[1:0] == 2'd0;
            hrd = rd && sel_c && addr[1:0] == 2'd2;
            cwr = wr && sel_c && addr[1:0] == 2'd0;
            take = req[c] && m_en[c] && !m_val[c] && !hrd;
            drop = req[c] && m_en[c] && (m_val[c] || hrd);
            if (cwr) m_en[c] = wb;
            if (hrd) m_val[c] = 1'b0;
            if (take) begin m_val[c] = 1'b1; m_st[c] = tm; end
            if (crd) m_mis[c] = 1'b0;
            if (drop) m_mis[c] = 1'b1;
        end
        #1;
        cap_req = '0; reg_rd = 1'b0; reg_wr = 1'b0;
    endtask

    function automatic logic [2:0] ad(input int ch, input int sel);
        return {ch[0], sel[1:0]};
    endfunction

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_en[c] = 0; m_val[c] = 0; m_mis[c] = 0; m_st[c] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state of all registers
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < 4; s++)
                cyc(2'b00, 1, 0, ad(c, s), 0, '0, "R1 reset value");

        // near-exhaustive sweep: enable x locked x high read x request, per slot
        for (int ch = 0; ch < 2; ch++) begin
            for (int combo = 0; combo < 16; combo++) begin
                logic en, lock, hird, rq;
                logic [63:0] ta, tb;
                logic [1:0] rv;
                string tag;
                en = combo[0]; lock = combo[1]; hird = combo[2]; rq = combo[3];
                ta = 64'h1111_2222_0000_0000 * (combo + 1) + 64'(ch) + 64'h35;
                tb = ~ta ^ 64'h0F0F_0000_0000_00F0;
                rv = rq ? 2'(1 << ch) : 2'b00;
                if (hird && rq && en)  tag = "R6 read wins over request";
                else if (!en)          tag = "R5 enable gate";
                else if (lock)         tag = "R3 locked slot holds";
                else                   tag = "R2 capture";
                cyc(2'b00, 0, 1, ad(ch, 0), 1, '0, "setup");
                if (lock) cyc(2'(1 << ch), 0, 0, ad(ch, 0), 0, ta, "setup");
                else      cyc(2'b00, 1, 0, ad(ch, 2), 0, '0, "R4 release in setup");
                cyc(2'b00, 0, 1, ad(ch, 0), en, '0, "setup");
                cyc(2'b00, 1, 0, ad(ch, 0), 0, '0, "R7 control before event");
                cyc(rv, hird, 0, ad(ch, 2), 0, tb, tag);
                cyc(2'b00, 1, 0, ad(ch, 0), 0, '0, tag);
                cyc(2'b00, 1, 0, ad(1 - ch, 0), 0, '0, "R8 other slot unchanged");
                cyc(2'b00, 1, 0, ad(ch, 1), 0, '0, tag);
                cyc(2'b00, 1, 0, ad(ch, 0), 0, '0, "R4 low read keeps valid");
                cyc(2'b00, 1, 0, ad(ch, 2), 0, '0, "R10 high read returns stamp");
                cyc(2'b00, 1, 0, ad(ch, 0), 0, '0, "R4 high read releases");
            end
        end

        // R7: control read coinciding with a new drop keeps missed set
        cyc(2'b00, 0, 1, ad(1, 0), 1, '0, "setup");
        cyc(2'b10, 0, 0, ad(1, 0), 0, 64'hDEAD_BEEF_0000_0007, "setup");
        cyc(2'b10, 0, 0, ad(1, 0), 0, 64'h1, "setup");
        cyc(2'b10, 1, 0, ad(1, 0), 0, 64'h2, "R7 read with drop");
        cyc(2'b00, 1, 0, ad(1, 0), 0, '0, "R7 missed still set");
        cyc(2'b00, 1, 0, ad(1, 0), 0, '0, "R7 missed cleared");

        // R9: writes to stamp words and reserved select
        cyc(2'b00, 0, 1, ad(1, 1), 0, '0, "setup");
        cyc(2'b00, 0, 1, ad(1, 2), 1, '0, "setup");
        cyc(2'b00, 0, 1, ad(1, 3), 0, '0, "setup");
        cyc(2'b00, 1, 0, ad(1, 1), 0, '0, "R9 stamp low unwritten");
        cyc(2'b00, 1, 0, ad(1, 0), 0, '0, "R9 enable unchanged");
        cyc(2'b00, 1, 0, ad(1, 3), 0, '0, "R9 reserved reads zero");
        cyc(2'b00, 1, 0, ad(0, 3), 0, '0, "R9 reserved reads zero");
        cyc(2'b00, 1, 0, ad(1, 2), 0, '0, "R10 final high read");
        cyc(2'b00, 1, 0, ad(1, 0), 0, '0, "R4 released");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule